// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

A CRC accelerator behind a 32-bit register bus. Software or a DMA master writes data words of 8, 16 or 32 bits. The engine can optionally mirror the bits of each byte of a word and can optionally invert the word. The word is then folded into a running CRC, one byte per clock, starting with the most significant valid byte. The CRC register is shifted MSB-first, and one of four generator polynomials is selected at run time.

The engine always presents the running result on a checksum register and on a matching output port. The result can optionally be mirrored across all 32 bits and optionally inverted. A self-clearing engine reset loads the seed register into the CRC state. The bus has four word-addressed registers, selected by `bus_addr`:

- 0: control
- 1: write data
- 2: seed
- 3: checksum (read-only)

Reads are combinational.

Top module: `crc_engine`

## Requirements
- R1: After `rst_n` is released, all four registers read 0, `checksum` is 0 and `busy` is 0.
- R2: Control fields sit at fixed bit positions: bit 0 enable, bit 1 engine reset, bit 24 input byte-mirror, bit 25 output word-mirror, bit 26 input invert, bit 27 output invert, bits 29:28 write length, bits 31:30 mode. All other control bits read as 0.
- R3: The mode code selects the polynomial. Mode 00 is CCITT with 16 bits and polynomial 0x1021. Mode 01 is 8 bits with 0x07. Mode 10 is 16 bits with 0x8005. Mode 11 is 32 bits with 0x04C11DB7. The CRC is computed MSB-first, with no final XOR. The check values for ASCII "123456789" are 0x29B1 (mode 00, seed 0xFFFF), 0xF4 (mode 01, seed 0), 0xFEE8 (mode 10, seed 0) and 0x0376E6E7 (mode 11, seed 0xFFFFFFFF).
- R4: The write length code selects the valid data. Code 00 uses data[7:0], code 01 uses data[15:0], and codes 10 and 11 use all 32 bits. Bytes are absorbed from the most significant valid byte downward, one per clock. After an accepted write, `busy` stays high for exactly as many cycles as there are valid bytes.
- R5: When input byte-mirror is set, each byte is bit-reversed in place before it enters the CRC. For example, writing 0xAABBCCDD feeds 0x55DD33BB.
- R6: When input invert is set, the data is ones-complemented before it enters the CRC. This happens after any mirroring.
- R7: When output word-mirror is set, the checksum is the 32-bit bit reversal of the masked CRC state. For example, a state of 0xDD7B0F2E reads as 0x74F0DEBB.
- R8: When output invert is set, the checksum is the ones-complement of the 32-bit value that follows any mirroring.
- R9: Writing 1 to control bit 1 starts the engine reset, which lasts RST_CYCLES cycles. During those cycles bit 1 reads as 1 and `busy` is high. The reset aborts any partly absorbed word and loads the seed, masked to the mode width, into the CRC state. Bit 1 then clears by itself, and all other control bits keep their written values.
- R10: While enable is 0, a data-register write changes neither the data register nor the checksum.
- R11: A data-register write while `busy` is high is dropped. The data register and the checksum are left as if it never happened.
- R12: The seed register reads back as written. Writing it does not change the checksum until the next engine reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control, 1 data, 2 seed, 3 checksum |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| busy | output | 1 | Engine absorbing a word or in engine reset |
| checksum | output | 32 | Same value as the checksum register |

## Verification
The assertions take for granted that the mode field is not rewritten while a word is being absorbed. They also take for granted that a data write is a single-cycle strobe that is sampled once. The bench keeps within this: it rewrites control only after `busy` has dropped, and it holds each strobe for exactly one clock. The one exception is the stall case, where a second data write is issued on purpose while the first word is still in flight.

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int RST_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy,
  output logic [31:0] checksum
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic        en_q, irev_q, orev_q, iinv_q, oinv_q;
  logic [1:0]  len_q, mode_q;
  logic [31:0] dat_q, seed_q, crc_q, buf_q;
  logic [2:0]  cnt_q;
  logic [RCW-1:0] rcnt_q;

  function automatic int wid(input logic [1:0] m);
    case (m)
      2'd1:    return 8;
      2'd3:    return 32;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] m);
    case (m)
      2'd1:    return 32'h0000_00FF;
      2'd3:    return 32'hFFFF_FFFF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] gpoly(input logic [1:0] m);
    case (m)
      2'd0:    return 32'h0000_1021;
      2'd1:    return 32'h0000_0007;
      2'd2:    return 32'h0000_8005;
      default: return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b,
                                           input logic [1:0] m);
    int sh;
    logic [31:0] a, p;
    sh = 32 - wid(m);
    a  = c << sh;
    p  = gpoly(m) << sh;
    for (int i = 7; i >= 0; i--)
      a = {a[30:0], 1'b0} ^ (((a[31] ^ b[i]) != 1'b0) ? p : 32'h0);
    return a >> sh;
  endfunction

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 8; i++)
        r[8*k + i] = w[8*k + 7 - i];
    return r;
  endfunction

  function automatic logic [31:0] rev_word(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = w[31 - i];
    return r;
  endfunction

  wire wr       = bus_sel & bus_wr;
  wire wr_ctl   = wr && bus_addr == 2'd0;
  wire wr_dat   = wr && bus_addr == 2'd1;
  wire wr_seed  = wr && bus_addr == 2'd2;
  wire rst_act  = rcnt_q != '0;
  assign busy   = (cnt_q != 3'd0) | rst_act;
  wire dat_take = wr_dat & en_q & ~busy;

  logic [2:0]  nbytes;
  logic [31:0] din_mir, din;
  assign nbytes  = (len_q == 2'd0) ? 3'd1 : (len_q == 2'd1) ? 3'd2 : 3'd4;
  assign din_mir = irev_q ? rev_bytes(bus_wdata) : bus_wdata;
  assign din     = iinv_q ? ~din_mir : din_mir;

  logic [31:0] res_m, res_r;
  assign res_m    = crc_q & wmask(mode_q);
  assign res_r    = orev_q ? rev_word(res_m) : res_m;
  assign checksum = oinv_q ? ~res_r : res_r;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {mode_q, len_q, oinv_q, iinv_q, orev_q, irev_q,
                            22'd0, rst_act, en_q};
      2'd1:    bus_rdata = dat_q;
      2'd2:    bus_rdata = seed_q;
      default: bus_rdata = checksum;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, irev_q, orev_q, iinv_q, oinv_q} <= '0;
      len_q  <= '0;
      mode_q <= '0;
      dat_q  <= '0;
      seed_q <= '0;
      crc_q  <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
      rcnt_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= bus_wdata[0];
        irev_q <= bus_wdata[24];
        orev_q <= bus_wdata[25];
        iinv_q <= bus_wdata[26];
        oinv_q <= bus_wdata[27];
        len_q  <= bus_wdata[29:28];
        mode_q <= bus_wdata[31:30];
      end
      if (wr_ctl && bus_wdata[1]) rcnt_q <= RCW'(RST_CYCLES);
      else if (rst_act)           rcnt_q <= rcnt_q - 1'b1;
      if (wr_seed) seed_q <= bus_wdata;
      if (rst_act) begin
        crc_q <= seed_q & wmask(mode_q);
        cnt_q <= '0;
        buf_q <= '0;
      end else if (cnt_q != 3'd0) begin
        crc_q <= crc_step(crc_q, buf_q[31:24], mode_q);
        buf_q <= buf_q << 8;
        cnt_q <= cnt_q - 1'b1;
      end else if (dat_take) begin
        dat_q <= bus_wdata;
        buf_q <= din << (8 * (4 - int'(nbytes)));
        cnt_q <= nbytes;
      end
    end
  end

  AST_RESET_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> crc_q == ($past(seed_q) & wmask($past(mode_q))));  // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1 && en_q && !busy) |=> busy);  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en_q) |=> $stable(crc_q));  // R10
  AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1 && !en_q) |=> $stable(dat_q));  // R10
  AST_STALL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1 && busy) |=> $stable(dat_q));  // R11
endmodule

// File: tb/crc_engine_tb_top.sv
module crc_engine_tb_top;
  localparam int RSTC = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, checksum;
  logic busy;

  crc_engine #(.RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .checksum(checksum));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  logic [1:0] m_mode = 0, m_len = 0;
  bit m_en = 0, m_irev = 0, m_orev = 0, m_iinv = 0, m_oinv = 0;
  logic [31:0] m_seed = 0, m_crc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] b_mask(input logic [1:0] m);
    return (m == 2'd1) ? 32'hFF : (m == 2'd3) ? 32'hFFFFFFFF : 32'hFFFF;
  endfunction

  function automatic logic [31:0] b_byte(input logic [31:0] c, input logic [7:0] b);
    int w;
    logic [31:0] p;
    logic top;
    w = (m_mode == 2'd1) ? 8 : (m_mode == 2'd3) ? 32 : 16;
    p = (m_mode == 2'd0) ? 32'h1021 : (m_mode == 2'd1) ? 32'h07 :
        (m_mode == 2'd2) ? 32'h8005 : 32'h04C11DB7;
    for (int i = 7; i >= 0; i--) begin
      top = c[w-1] ^ b[i];
      c = c << 1;
      if (top) c = c ^ p;
      c = c & b_mask(m_mode);
    end
    return c;
  endfunction

  function automatic logic [31:0] b_out(input logic [31:0] c);
    logic [31:0] v, r;
    v = c & b_mask(m_mode);
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    if (m_orev) v = r;
    return m_oinv ? ~v : v;
  endfunction

  function automatic void b_feed(input logic [31:0] d);
    logic [31:0] v;
    int nb;
    v = d;
    if (m_irev)
      for (int i = 0; i < 32; i++) v[i] = d[(i/8)*8 + 7 - (i%8)];
    if (m_iinv) v = ~v;
    nb = (m_len == 2'd0) ? 1 : (m_len == 2'd1) ? 2 : 4;
    for (int k = nb - 1; k >= 0; k--) m_crc = b_byte(m_crc, v[8*k +: 8]);
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  function automatic logic [31:0] ctl_word(input bit rst);
    return {m_mode, m_len, m_oinv, m_iinv, m_orev, m_irev, 22'd0, rst, m_en};
  endfunction

  task automatic set_ctl(input bit rst, output int n);
    if (rst) begin
      m_crc = m_seed & b_mask(m_mode);
      exp_q.push_back(b_out(m_crc)); tag_q.push_back("R9");
    end
    bus_write(2'd0, ctl_word(rst));
    wait_idle(n);
  endtask

  task automatic feed(input logic [31:0] d, input string tag, output int n);
    b_feed(d);
    exp_q.push_back(b_out(m_crc)); tag_q.push_back(tag);
    bus_write(2'd1, d);
    wait_idle(n);
  endtask

  initial begin : monitor
    bit pb = 0;
    logic [31:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (pb && !busy) begin
        if (exp_q.size() == 0) chk(0, "SCOREBOARD", checksum, 32'h0);
        else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(checksum == e, t, checksum, e);
        end
      end
      pb = busy;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic config_run(input logic [1:0] mode, input logic [31:0] seed);
    int n;
    m_mode = mode; m_len = 0; m_irev = 0; m_orev = 0; m_iinv = 0; m_oinv = 0; m_en = 1;
    m_seed = seed;
    bus_write(2'd2, seed);
    set_ctl(1, n);
  endtask

  initial begin : driver
    logic [31:0] r, lf, c1, c2;
    int n;
    logic [31:0] kv [4];
    kv[0] = 32'h29B1; kv[1] = 32'hF4; kv[2] = 32'hFEE8; kv[3] = 32'h0376E6E7;

    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], r);
      chk(r == 0, "R1 reg", r, 0);
    end
    chk(checksum == 0 && busy == 0, "R1 outputs", {busy, checksum[30:0]}, 0);

    bus_write(2'd0, 32'hFFFF_FFFD);
    bus_read(2'd0, r);
    chk(r == 32'hFF00_0001, "R2 layout", r, 32'hFF00_0001);
    bus_write(2'd0, 32'h0);

    for (int m = 0; m < 4; m++) begin
      config_run(m[1:0], (m == 0) ? 32'hFFFF : (m == 3) ? 32'hFFFFFFFF : 32'h0);
      for (int i = 0; i < 9; i++) feed(32'h31 + i, "R3", n);
      chk(checksum == kv[m], "R3 check value", checksum, kv[m]);
    end

    config_run(2'd3, 32'hFFFFFFFF);
    m_len = 2'd2; set_ctl(0, n);
    feed(32'h31323334, "R4", n);
    chk(n == 4, "R4 busy 32b", n, 4);
    feed(32'h35363738, "R4", n);
    m_len = 2'd0; set_ctl(0, n);
    feed(32'hAB_CD_EF39, "R4", n);
    chk(checksum == 32'h0376E6E7, "R4 32b words", checksum, 32'h0376E6E7);

    config_run(2'd0, 32'hFFFF);
    m_len = 2'd1; set_ctl(0, n);
    for (int i = 0; i < 4; i++) begin
      feed({16'hDEAD, 8'h31 + 8'(2*i), 8'h32 + 8'(2*i)}, "R4", n);
      chk(n == 2, "R4 busy 16b", n, 2);
    end
    m_len = 2'd0; set_ctl(0, n);
    feed(32'h39, "R4", n);
    chk(checksum == 32'h29B1, "R4 16b words", checksum, 32'h29B1);

    config_run(2'd3, 32'h0);
    m_len = 2'd3; m_irev = 1; set_ctl(0, n);
    feed(32'hAABBCCDD, "R5", n); c1 = checksum;
    config_run(2'd3, 32'h0);
    m_len = 2'd3; set_ctl(0, n);
    feed(32'h55DD33BB, "R5", n); c2 = checksum;
    chk(c1 == c2, "R5 byte mirror", c1, c2);

    config_run(2'd2, 32'h1234);
    m_len = 2'd1; m_iinv = 1; set_ctl(0, n);
    feed(32'h0000_5A0F, "R6", n); c1 = checksum;
    config_run(2'd2, 32'h1234);
    m_len = 2'd1; set_ctl(0, n);
    feed(32'h0000_A5F0, "R6", n); c2 = checksum;
    chk(c1 == c2, "R6 input invert", c1, c2);

    config_run(2'd3, 32'hDD7B0F2E);
    m_orev = 1; set_ctl(0, n);
    chk(checksum == 32'h74F0DEBB, "R7 word mirror", checksum, 32'h74F0DEBB);
    m_oinv = 1; set_ctl(0, n);
    chk(checksum == ~32'h74F0DEBB, "R8 output invert", checksum, ~32'h74F0DEBB);
    m_orev = 0; set_ctl(0, n);
    chk(checksum == 32'h2284F0D1, "R8 output invert", checksum, 32'h2284F0D1);

    m_orev = 0; m_oinv = 0; m_mode = 2'd2; m_len = 2'd1; m_irev = 1;
    m_seed = 32'hABCD_1357;
    bus_write(2'd2, m_seed);
    m_crc = m_seed & b_mask(m_mode);
    exp_q.push_back(b_out(m_crc)); tag_q.push_back("R9");
    bus_write(2'd0, ctl_word(1));
    #1 r = bus_rdata;
    bus_read(2'd0, r);
    chk(r == ctl_word(1), "R9 bit set", r, ctl_word(1));
    wait_idle(n);
    chk(n == RSTC - 1, "R9 duration", n, RSTC - 1);
    bus_read(2'd0, r);
    chk(r == ctl_word(0), "R9 self clear", r, ctl_word(0));
    chk(checksum == 32'h1357, "R9 seed reload", checksum, 32'h1357);
    m_irev = 0; m_len = 2'd2; set_ctl(0, n);
    bus_write(2'd1, 32'h11223344);
    m_seed = 32'h0000_7777;
    bus_write(2'd2, m_seed);
    set_ctl(1, n);
    chk(checksum == 32'h7777, "R9 abort", checksum, 32'h7777);

    feed(32'h0BADF00D, "R10", n);
    m_en = 0; set_ctl(0, n);
    c1 = checksum;
    bus_write(2'd1, 32'hCAFEBABE);
    repeat (6) @(negedge clk);
    chk(checksum == c1, "R10 crc kept", checksum, c1);
    bus_read(2'd1, r);
    chk(r == 32'h0BADF00D, "R10 data kept", r, 32'h0BADF00D);

    m_en = 1; set_ctl(0, n);
    b_feed(32'h01020304);
    exp_q.push_back(b_out(m_crc)); tag_q.push_back("R11");
    bus_write(2'd1, 32'h01020304);
    bus_write(2'd1, 32'hFFFFFFFF);
    wait_idle(n);
    repeat (6) @(negedge clk);
    chk(checksum == b_out(m_crc), "R11 stall crc", checksum, b_out(m_crc));
    bus_read(2'd1, r);
    chk(r == 32'h01020304, "R11 stall data", r, 32'h01020304);

    c1 = checksum;
    bus_write(2'd2, 32'h5555AAAA);
    m_seed = 32'h5555AAAA;
    bus_read(2'd2, r);
    chk(r == 32'h5555AAAA, "R12 seed readback", r, 32'h5555AAAA);
    chk(checksum == c1, "R12 no effect", checksum, c1);
    set_ctl(1, n);
    chk(checksum == 32'hAAAA, "R12 applied on reset", checksum, 32'hAAAA);

    lf = 32'hACE1_2468;
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 3; l++)
        for (int f = 0; f < 16; f++) begin
          m_mode = m[1:0]; m_len = l[1:0];
          {m_irev, m_iinv, m_orev, m_oinv} = f[3:0];
          m_seed = lf;
          bus_write(2'd2, m_seed);
          set_ctl(1, n);
          for (int w = 0; w < 2; w++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            feed(lf, (f[3] | f[2]) ? "R5 R6 sweep" : "R3 R4 R7 R8 sweep", n);
          end
        end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "SCOREBOARD drain", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule